// File: doc/BRIEF.md
# Interrupt Presentation Controller

This block sits between one processor core and the interrupt sources around it. It holds two byte-wide registers. The first is the current processor priority, which is the threshold an interrupt must beat. The second is an inter-processor request priority, which lets software raise a self-interrupt. The best pending external source arrives from a separate source controller as a source index and a priority. The block picks the more favoured of that source and the inter-processor request, where a lower number is more favoured. It compares the winner against the current priority and drives one level-sensitive interrupt line to the core.

Software reaches the block through a Wishbone-style register port with byte addresses. Only the low eight address bits reach it. The 32-bit registers are big-endian: the byte at the lowest address is register bits 31:24. Reading the combined accept register takes the presented interrupt. That read returns the old priority and the interrupt identity, and it raises the current priority to the priority of the taken interrupt. Writing the same word back restores the old priority, and this write is the end-of-interrupt step. A separate poll register shows the same word and changes nothing.

Top module: `irq_presenter`

## Requirements
- R1: A bus request (cyc and stb high, ack low) is answered with `wb_ack_o` high for exactly one cycle, in the cycle after the request. Read data is valid with that ack.
- R2: Byte lane k (`wb_sel_i[k]`, `wb_dat_*[8k+7:8k]`) carries the register byte at offset+k, which is register bits [31-8k:24-8k]. The priority byte of every register is therefore lane 0.
- R3: A write to offset 0x0 with `wb_sel_i[0]` set loads the current priority from lane 0. A value of 0x00 blocks every interrupt, and 0xFF lets any pending one through.
- R4: A read at offset 0x4 returns {current priority, 16'h0, candidate id} and changes no state. The candidate id is 0 when nothing would be delivered.
- R5: A read at offset 0x0 while an interrupt is deliverable returns {old priority, 16'h0, id} and sets the current priority to the priority of the taken interrupt, so `irq_o` falls. When nothing is deliverable it returns id 0 and changes nothing.
- R6: A 32-bit write (sel 4'hF) to offset 0x0 of a word taken from R5 restores the priority held in its top byte. This is the end-of-interrupt step.
- R7: A write at offset 0xC with `wb_sel_i[0]` loads the inter-processor priority from lane 0. A value below 0xFF requests an interrupt at that priority, and 0xFF withdraws it. A read at 0xC returns {priority, 24'h0}.
- R8: `irq_o` is high exactly when the winning candidate priority is strictly lower than the current priority. It follows any state or input change one clock later.
- R9: The inter-processor request reports id 2. The external source reports id 16 + `ext_src_i`. An external priority of 0xFF means no external source.
- R10: When the inter-processor and external priorities are equal, the inter-processor request wins.
- R11: Reset (synchronous, active high) sets the current priority to 0x00 and the inter-processor priority to 0xFF, and clears `irq_o` and `wb_ack_o`.
- R12: Writes to offsets 0x4 and 0x8, and to any offset at or above 0x10, change nothing. Reads of those reserved offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| wb_cyc_i | input | 1 | Bus cycle |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | ADDR_W (8) | Byte address, low bits of the system address |
| wb_sel_i | input | 4 | Byte lane enables |
| wb_dat_i | input | 32 | Write data |
| wb_dat_o | output | 32 | Read data |
| wb_ack_o | output | 1 | Transfer acknowledge |
| ext_src_i | input | SRC_W (4) | Index of best pending external source |
| ext_pri_i | input | 8 | Priority of that source, 0xFF for none |
| irq_o | output | 1 | Level interrupt to the core |

## Verification
The bench builds the block with its defaults: a 4-bit source index, 8-bit priorities, inter-processor id 2 and external base 16. At these values, every ordered combination of eight chosen priority levels for the threshold, the inter-processor request and the external source can be swept. The eight levels include 0x00, the neighbours of the tie points and 0xFE/0xFF. Each combination is driven through the line check, the poll, the accept and the end-of-interrupt. A second sweep walks all 16 source indices, so every external id value is observed.

// File: rtl/irq_presenter_pkg.sv
package irq_presenter_pkg;

    localparam int PRI_W = 8;
    localparam int ID_W  = 8;
    localparam logic [PRI_W-1:0] PRI_NONE = 8'hFF;

    typedef enum logic [2:0] {
        RS_ACCEPT,
        RS_POLL,
        RS_RSVD,
        RS_IPI,
        RS_NONE
    } reg_sel_e;

    typedef struct packed {
        logic             valid;
        logic [PRI_W-1:0] pri;
        logic [ID_W-1:0]  id;
    } cand_t;

    typedef struct packed {
        logic     req;
        logic     rd;
        reg_sel_e rsel;
        logic     prio_wr;
        logic     ipi_wr;
        logic     take;
    } bus_op_t;

    // Bus lane k holds register byte k counted from the top (big-endian).
    function automatic logic [31:0] swap_lanes(input logic [31:0] x);
        logic [31:0] y;
        for (int k = 0; k < 4; k++) begin
            y[8*k +: 8] = x[31-8*k -: 8];
        end
        return y;
    endfunction

    function automatic logic more_favoured(input logic [PRI_W-1:0] a,
                                           input logic [PRI_W-1:0] b);
        return a < b;
    endfunction

endpackage

// File: rtl/irq_presenter_pick.sv
module irq_presenter_pick
    import irq_presenter_pkg::*;
#(
    parameter int SRC_W    = 4,
    parameter int IPI_ID   = 2,
    parameter int EXT_BASE = 16
) (
    input  logic [PRI_W-1:0] ipi_pri,
    input  logic [SRC_W-1:0] ext_src,
    input  logic [PRI_W-1:0] ext_pri,
    output cand_t            best
);
    cand_t ipi_c;
    cand_t ext_c;

    always_comb begin
        ipi_c.valid = (ipi_pri != PRI_NONE);
        ipi_c.pri   = ipi_pri;
        ipi_c.id    = ID_W'(IPI_ID);
        ext_c.valid = (ext_pri != PRI_NONE);
        ext_c.pri   = ext_pri;
        ext_c.id    = ID_W'(EXT_BASE) + ID_W'(ext_src);
    end

    // Equal priorities: the inter-processor request is kept.
    always_comb begin
        if (ipi_c.valid && (!ext_c.valid || !more_favoured(ext_c.pri, ipi_c.pri)))
            best = ipi_c;
        else if (ext_c.valid)
            best = ext_c;
        else
            best = '{valid: 1'b0, pri: PRI_NONE, id: '0};
    end
endmodule

// File: rtl/irq_presenter_decode.sv
module irq_presenter_decode
    import irq_presenter_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              cyc,
    input  logic              stb,
    input  logic              we,
    input  logic [ADDR_W-1:0] adr,
    input  logic [3:0]        sel,
    input  logic              ack_q,
    output bus_op_t           op
);
    logic in_range;
    logic req;

    assign req      = cyc & stb & ~ack_q;
    assign in_range = (adr[ADDR_W-1:4] == '0);

    always_comb begin
        op      = '0;
        op.rsel = RS_NONE;
        op.req  = req;
        op.rd   = req & ~we;
        if (in_range) begin
            unique case (adr[3:2])
                2'd0:    op.rsel = RS_ACCEPT;
                2'd1:    op.rsel = RS_POLL;
                2'd2:    op.rsel = RS_RSVD;
                default: op.rsel = RS_IPI;
            endcase
        end
        op.take    = req & ~we & (op.rsel == RS_ACCEPT);
        op.prio_wr = req &  we & (op.rsel == RS_ACCEPT) & sel[0];
        op.ipi_wr  = req &  we & (op.rsel == RS_IPI)    & sel[0];
    end
endmodule

// File: rtl/irq_presenter_regs.sv
module irq_presenter_regs
    import irq_presenter_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  bus_op_t          op,
    input  logic [31:0]      wreg,
    input  cand_t            best,
    output logic [PRI_W-1:0] cppr,
    output logic [PRI_W-1:0] ipi_pri,
    output logic [31:0]      rreg,
    output logic             take_fire,
    output logic             deliver
);
    logic [ID_W-1:0] shown_id;
    logic [31:0]     status_word;

    assign deliver     = best.valid & more_favoured(best.pri, cppr);
    assign shown_id    = deliver ? best.id : '0;
    assign status_word = {cppr, 16'h0, shown_id};
    assign take_fire   = op.take & deliver;

    always_ff @(posedge clk) begin
        if (rst) begin
            cppr    <= 8'h00;
            ipi_pri <= PRI_NONE;
        end else begin
            if (take_fire)
                cppr <= best.pri;
            else if (op.prio_wr)
                cppr <= wreg[31:24];
            if (op.ipi_wr)
                ipi_pri <= wreg[31:24];
        end
    end

    always_comb begin
        unique case (op.rsel)
            RS_ACCEPT: rreg = status_word;
            RS_POLL:   rreg = status_word;
            RS_IPI:    rreg = {ipi_pri, 24'h0};
            default:   rreg = '0;
        endcase
    end
endmodule

// File: rtl/irq_presenter.sv
module irq_presenter
    import irq_presenter_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int SRC_W    = 4,
    parameter int IPI_ID   = 2,
    parameter int EXT_BASE = 16
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wb_cyc_i,
    input  logic              wb_stb_i,
    input  logic              wb_we_i,
    input  logic [ADDR_W-1:0] wb_adr_i,
    input  logic [3:0]        wb_sel_i,
    input  logic [31:0]       wb_dat_i,
    output logic [31:0]       wb_dat_o,
    output logic              wb_ack_o,
    input  logic [SRC_W-1:0]  ext_src_i,
    input  logic [PRI_W-1:0]  ext_pri_i,
    output logic              irq_o
);
    bus_op_t          op;
    cand_t            best;
    logic [PRI_W-1:0] cppr;
    logic [PRI_W-1:0] ipi_pri;
    logic [31:0]      rreg;
    logic [31:0]      wreg;
    logic             take_fire;
    logic             deliver;

    assign wreg = swap_lanes(wb_dat_i);

    irq_presenter_decode #(.ADDR_W(ADDR_W)) u_decode (
        .cyc   (wb_cyc_i),
        .stb   (wb_stb_i),
        .we    (wb_we_i),
        .adr   (wb_adr_i),
        .sel   (wb_sel_i),
        .ack_q (wb_ack_o),
        .op    (op)
    );

    irq_presenter_pick #(.SRC_W(SRC_W), .IPI_ID(IPI_ID), .EXT_BASE(EXT_BASE)) u_pick (
        .ipi_pri (ipi_pri),
        .ext_src (ext_src_i),
        .ext_pri (ext_pri_i),
        .best    (best)
    );

    irq_presenter_regs u_regs (
        .clk       (clk_i),
        .rst       (rst_i),
        .op        (op),
        .wreg      (wreg),
        .best      (best),
        .cppr      (cppr),
        .ipi_pri   (ipi_pri),
        .rreg      (rreg),
        .take_fire (take_fire),
        .deliver   (deliver)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            wb_ack_o <= 1'b0;
            wb_dat_o <= '0;
            irq_o    <= 1'b0;
        end else begin
            wb_ack_o <= op.req;
            if (op.rd)
                wb_dat_o <= swap_lanes(rreg);
            irq_o <= deliver;
        end
    end
endmodule

// File: rtl/irq_presenter_chk.sv
module irq_presenter_chk
    import irq_presenter_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              wb_cyc_i,
    input logic              wb_stb_i,
    input logic              wb_we_i,
    input logic [ADDR_W-1:0] wb_adr_i,
    input logic              wb_ack_o,
    input logic [PRI_W-1:0]  ext_pri_i,
    input logic              irq_o,
    input logic [PRI_W-1:0]  cppr,
    input logic [PRI_W-1:0]  ipi_pri,
    input logic              take_fire,
    input cand_t             best
);
    logic req;
    assign req = wb_cyc_i & wb_stb_i & ~wb_ack_o;

    AST_ACK_PULSE: assert property (@(posedge clk_i) disable iff (rst_i)
        wb_ack_o |=> !wb_ack_o); // R1
    AST_ACK_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (rst_i)
        req |=> wb_ack_o); // R1
    AST_ZERO_PRIO_MASKS: assert property (@(posedge clk_i) disable iff (rst_i)
        (cppr == 8'h00) |=> !irq_o); // R3
    AST_POLL_NO_SIDE: assert property (@(posedge clk_i) disable iff (rst_i)
        (req && !wb_we_i && wb_adr_i == ADDR_W'(4)) |=> ($stable(cppr) && $stable(ipi_pri))); // R4
    AST_TAKE_RAISES_PRIO: assert property (@(posedge clk_i) disable iff (rst_i)
        take_fire |=> (cppr == $past(best.pri))); // R5
    AST_IPI_WITHDRAWN: assert property (@(posedge clk_i) disable iff (rst_i)
        (ipi_pri == 8'hFF && ext_pri_i == 8'hFF) |=> !irq_o); // R7
    AST_RSVD_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (rst_i)
        (req && wb_we_i && wb_adr_i == ADDR_W'(8)) |=> ($stable(cppr) && $stable(ipi_pri))); // R12
    AST_RESET_VALUES: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(rst_i) |-> (cppr == 8'h00 && ipi_pri == 8'hFF && !irq_o && !wb_ack_o)); // R11
endmodule

bind irq_presenter irq_presenter_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .wb_cyc_i  (wb_cyc_i),
    .wb_stb_i  (wb_stb_i),
    .wb_we_i   (wb_we_i),
    .wb_adr_i  (wb_adr_i),
    .wb_ack_o  (wb_ack_o),
    .ext_pri_i (ext_pri_i),
    .irq_o     (irq_o),
    .cppr      (cppr),
    .ipi_pri   (ipi_pri),
    .take_fire (take_fire),
    .best      (best)
);

// File: tb/irq_presenter_bench.sv
module irq_presenter_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cyc = 0, stb = 0, we = 0;
    logic [7:0]  adr = 0;
    logic [3:0]  sel = 0;
    logic [31:0] wdat = 0;
    logic [31:0] rdat;
    logic        ack;
    logic [3:0]  esrc = 0;
    logic [7:0]  epri = 8'hFF;
    logic        irq;
    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    irq_presenter u_irq_presenter (
        .clk_i(clk), .rst_i(rst), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
        .wb_adr_i(adr), .wb_sel_i(sel), .wb_dat_i(wdat), .wb_dat_o(rdat),
        .wb_ack_o(ack), .ext_src_i(esrc), .ext_pri_i(epri), .irq_o(irq)
    );

    function automatic logic [31:0] bsw(input logic [31:0] x);
        return {x[7:0], x[15:8], x[23:16], x[31:24]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic w, input logic [7:0] a, input logic [3:0] s,
                        input logic [31:0] d, output logic [31:0] r);
        @(negedge clk);
        cyc = 1; stb = 1; we = w; adr = a; sel = s; wdat = d;
        @(negedge clk);
        check("R1 ack", {31'b0, ack}, 32'd1);
        r = rdat;
        cyc = 0; stb = 0; we = 0;
        @(negedge clk);
        check("R1 single ack", {31'b0, ack}, 32'd0);
    endtask

    // model: returns {deliver, pri, id}
    function automatic logic [16:0] model(input logic [7:0] cp, input logic [7:0] mf,
                                          input logic [7:0] ep, input logic [3:0] es);
        logic [7:0] p; logic [7:0] id; logic v;
        v = 1'b0; p = 8'hFF; id = 8'd0;
        if (mf != 8'hFF && (ep == 8'hFF || mf <= ep)) begin v = 1; p = mf; id = 8'd2; end
        else if (ep != 8'hFF) begin v = 1; p = ep; id = 8'd16 + {4'd0, es}; end
        if (!(v && p < cp)) begin v = 0; id = 0; end
        return {v, p, id};
    endfunction

    logic [7:0] lv [8] = '{8'h00, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'hFE, 8'hFF};

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [16:0] m;
        logic [31:0] word;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R11 irq", {31'b0, irq}, 0);
        check("R11 ack", {31'b0, ack}, 0);
        xfer(0, 8'h04, 4'hF, 0, r);
        check("R11 cppr", bsw(r), 32'h0);
        xfer(0, 8'h0C, 4'hF, 0, r);
        check("R11 mfrr", bsw(r), 32'hFF000000);

        // byte-lane, reserved writes
        xfer(1, 8'h00, 4'h1, 32'h0000_0033, r);
        xfer(0, 8'h04, 4'h1, 0, r);
        check("R2 lane0 cppr", {24'b0, r[7:0]}, 32'h33);
        check("R3 cppr write", bsw(r), 32'h33000000);
        xfer(1, 8'h04, 4'hF, 32'h1111_1111, r);
        xfer(1, 8'h08, 4'hF, 32'h2222_2222, r);
        xfer(1, 8'h10, 4'hF, 32'h4444_4444, r);
        xfer(1, 8'h1C, 4'hF, 32'h5555_5555, r);
        xfer(0, 8'h04, 4'hF, 0, r);
        check("R12 cppr unchanged", bsw(r), 32'h33000000);
        xfer(0, 8'h0C, 4'hF, 0, r);
        check("R12 mfrr unchanged", bsw(r), 32'hFF000000);
        xfer(0, 8'h08, 4'hF, 0, r);
        check("R12 reserved read", r, 0);
        xfer(0, 8'h14, 4'hF, 0, r);
        check("R12 high read", r, 0);

        // exhaustive priority sweep
        esrc = 4'd5;
        for (int a = 0; a < 8; a++)
            for (int b = 0; b < 8; b++)
                for (int c = 0; c < 8; c++) begin
                    xfer(1, 8'h0C, 4'h1, {24'h0, lv[b]}, r);
                    xfer(0, 8'h0C, 4'hF, 0, r);
                    check("R7 mfrr read", {24'b0, r[7:0]}, {24'b0, lv[b]});
                    xfer(1, 8'h00, 4'h1, {24'h0, lv[a]}, r);
                    epri = lv[c];
                    @(negedge clk); @(negedge clk);
                    m = model(lv[a], lv[b], lv[c], esrc);
                    check("R8 irq level", {31'b0, irq}, {31'b0, m[16]});
                    xfer(0, 8'h04, 4'hF, 0, r);
                    check((lv[b] == lv[c]) ? "R10 poll tie" : "R4 poll", bsw(r),
                          {lv[a], 16'h0, m[7:0]});
                    xfer(0, 8'h00, 4'hF, 0, r);
                    word = bsw(r);
                    check((m[7:0] == 8'd2) ? "R9 take ipi" : "R5 take", word,
                          {lv[a], 16'h0, m[7:0]});
                    @(negedge clk);
                    check("R5 irq after take", {31'b0, irq}, 0);
                    xfer(0, 8'h04, 4'hF, 0, r);
                    check("R5 cppr after take", {24'b0, r[7:0]},
                          {24'b0, m[16] ? m[15:8] : lv[a]});
                    xfer(1, 8'h00, 4'hF, bsw(word), r);
                    @(negedge clk); @(negedge clk);
                    check("R6 eoi restores", {31'b0, irq}, {31'b0, m[16]});
                    xfer(0, 8'h04, 4'h1, 0, r);
                    check("R6 cppr restored", {24'b0, r[7:0]}, {24'b0, lv[a]});
                end

        // every external index
        xfer(1, 8'h0C, 4'h1, 32'hFF, r);
        xfer(1, 8'h00, 4'h1, 32'hFF, r);
        epri = 8'h10;
        for (int s = 0; s < 16; s++) begin
            esrc = s[3:0];
            @(negedge clk);
            xfer(0, 8'h04, 4'hF, 0, r);
            check("R9 ext id", bsw(r), {8'hFF, 16'h0, 8'(16 + s)});
        end
        epri = 8'hFF;
        @(negedge clk); @(negedge clk);
        check("R7 withdrawn none", {31'b0, irq}, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule